// File: doc/BRIEF.md
# Two-Register Stack Execution Unit

This block is the decode and execute half of a stack-machine datapath. The top of stack and the element under it live in two registers. Every deeper element lives in a stack memory with one read port and one write port. Each instruction either grows the stack by one or shrinks it by one. The decode stage therefore knows, one cycle early, which memory slot the instruction will touch, and it presents that address before execution begins.

In the execute stage, a growing instruction writes the second register into the memory (a spill). A shrinking instruction reloads the second register from the memory (a fill). Because the addresses are prepared a stage ahead, this movement needs neither a write-back stage nor any forwarding path. A spill that is followed directly by a fill of the same slot still returns the right word.

The unit accepts one instruction per cycle. The supported instructions are load-immediate, duplicate, discard, and five two-operand arithmetic and logic operations.

Top module: `stack_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `tos`, `nos` and `sp` are cleared to zero.
- R2: An instruction presented with `in_valid` high at rising edge k first shows its effect on `tos`, `nos` and `sp` just after edge k+1. A new instruction may be presented at every edge, with no stall.
- R3: `in_op` encodes 0 = load immediate, 1 = duplicate, 2 = discard, 3 = add, 4 = subtract, 5 = and, 6 = or, 7 = xor. Load immediate pushes `in_imm`.
- R4: Duplicate pushes a copy of the current `tos`.
- R5: A push (op 0 or 1) does four things: it moves the old `tos` into `nos`, stores the old `nos` in stack slot `sp+1`, increments `sp`, and places the new value in `tos`.
- R6: Discard (op 2) does three things: it moves `nos` into `tos`, reloads `nos` from stack slot `sp`, and decrements `sp`.
- R7: A two-operand op (3 to 7) writes `nos` op `tos` into `tos`, with subtract giving `nos - tos`, modulo 2^32. It then refills `nos` and updates `sp` exactly as discard does.
- R8: When a push is immediately followed by a pop, the pop fills `nos` with the word the push spilled, with no stall cycle.
- R9: A cycle with `in_valid` low leaves `tos`, `nos` and `sp` unchanged, whatever `in_op` and `in_imm` carry.
- R10: With x in `tos`, the four-instruction sequence "load -1, xor, load 1, add" leaves -x (modulo 2^32) in `tos`.
- R11: `sp` wraps modulo the stack depth of 256 in both directions, and the stack memory is reused circularly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Operation code (see R3) |
| in_imm | input | 32 | Immediate for load immediate |
| tos | output | 32 | Top-of-stack register |
| nos | output | 32 | Second stack element register |
| sp | output | 8 | Stack pointer: slot of the third element |

## Verification
A wrong precomputed address does not show at once. A bad spill slot corrupts nothing visible until the stack later shrinks back to that depth, when `nos` takes a wrong word. A bad fill slot shows in `nos` on the very next cycle after the pop executes. The deepest sweep therefore pushes past the full depth and pops all the way back, so every slot is written and then read again. A skew between the decode-stage pointer copy and `sp` becomes visible in a push-then-pop pair two cycles after issue.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

  typedef enum logic [2:0] {
    OP_LDI  = 3'd0,
    OP_DUP  = 3'd1,
    OP_DROP = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } sxu_op_e;

  function automatic logic op_grows(input sxu_op_e op);
    return (op == OP_LDI) || (op == OP_DUP);
  endfunction

endpackage

// File: rtl/sxu_stack_ram.sv
module sxu_stack_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] raddr_q;

  // Address registered, data read from the array: inferable as block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    raddr_q <= raddr;
  end

  assign rdata = mem[raddr_q];

endmodule

// File: rtl/sxu_decode.sv
module sxu_decode
  import sxu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_imm,
  output logic          dec_valid,
  output sxu_op_e       dec_op,
  output logic [DW-1:0] dec_imm,
  output logic          dec_push,
  output logic [AW-1:0] fill_addr,
  output logic [AW-1:0] spill_addr,
  output logic [AW-1:0] sp_ahead
);

  sxu_op_e op_in;
  logic    grow;

  assign op_in     = sxu_op_e'(in_op);
  assign grow      = op_grows(op_in);
  // A pop reloads from the slot the pointer names before it moves.
  assign fill_addr = sp_ahead;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_op     <= OP_LDI;
      dec_imm    <= '0;
      dec_push   <= 1'b0;
      spill_addr <= '0;
      sp_ahead   <= '0;
    end else begin
      dec_valid  <= in_valid;
      dec_op     <= op_in;
      dec_imm    <= in_imm;
      dec_push   <= in_valid && grow;
      spill_addr <= sp_ahead + AW'(1);
      if (in_valid) begin
        if (grow) sp_ahead <= sp_ahead + AW'(1);
        else      sp_ahead <= sp_ahead - AW'(1);
      end
    end
  end

endmodule

// File: rtl/sxu_alu.sv
module sxu_alu
  import sxu_pkg::*;
#(
  parameter int DW = 32
) (
  input  sxu_op_e       op,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] top,
  input  logic [DW-1:0] second,
  output logic [DW-1:0] result
);

  always_comb begin
    unique case (op)
      OP_LDI:  result = imm;
      OP_DUP:  result = top;
      OP_DROP: result = second;
      OP_ADD:  result = second + top;
      OP_SUB:  result = second - top;
      OP_AND:  result = second & top;
      OP_OR:   result = second | top;
      OP_XOR:  result = second ^ top;
      default: result = top;
    endcase
  end

endmodule

// File: rtl/sxu_execute.sv
module sxu_execute #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic          dec_push,
  input  logic [DW-1:0] alu_result,
  input  logic [DW-1:0] fill_data,
  output logic          spill_we,
  output logic [DW-1:0] spill_data,
  output logic [DW-1:0] tos_q,
  output logic [DW-1:0] nos_q,
  output logic [AW-1:0] sp_q
);

  assign spill_we   = dec_valid && dec_push;
  assign spill_data = nos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      nos_q <= '0;
      sp_q  <= '0;
    end else if (dec_valid) begin
      tos_q <= alu_result;
      if (dec_push) begin
        nos_q <= tos_q;
        sp_q  <= sp_q + AW'(1);
      end else begin
        nos_q <= fill_data;
        sp_q  <= sp_q - AW'(1);
      end
    end
  end

  AST_PUSH_SHIFTS_TOS: assert property (@(posedge clk) disable iff (rst)
    spill_we |=> nos_q == $past(tos_q)); // R5

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> $stable(tos_q) && $stable(nos_q) && $stable(sp_q)); // R9

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import sxu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_imm,
  output logic [DW-1:0] tos,
  output logic [DW-1:0] nos,
  output logic [AW-1:0] sp
);

  logic          dec_valid;
  sxu_op_e       dec_op;
  logic [DW-1:0] dec_imm;
  logic          dec_push;
  logic [AW-1:0] fill_addr;
  logic [AW-1:0] spill_addr;
  logic [AW-1:0] sp_ahead;
  logic [DW-1:0] alu_result;
  logic [DW-1:0] fill_data;
  logic          spill_we;
  logic [DW-1:0] spill_data;

  sxu_decode #(.DW(DW), .DEPTH(DEPTH)) u_decode (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_imm    (in_imm),
    .dec_valid (dec_valid),
    .dec_op    (dec_op),
    .dec_imm   (dec_imm),
    .dec_push  (dec_push),
    .fill_addr (fill_addr),
    .spill_addr(spill_addr),
    .sp_ahead  (sp_ahead)
  );

  sxu_stack_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (spill_we),
    .waddr(spill_addr),
    .wdata(spill_data),
    .raddr(fill_addr),
    .rdata(fill_data)
  );

  sxu_alu #(.DW(DW)) u_alu (
    .op    (dec_op),
    .imm   (dec_imm),
    .top   (tos),
    .second(nos),
    .result(alu_result)
  );

  sxu_execute #(.DW(DW), .DEPTH(DEPTH)) u_exec (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .dec_push  (dec_push),
    .alu_result(alu_result),
    .fill_data (fill_data),
    .spill_we  (spill_we),
    .spill_data(spill_data),
    .tos_q     (tos),
    .nos_q     (nos),
    .sp_q      (sp)
  );

  AST_SPILL_SLOT_ABOVE_SP: assert property (@(posedge clk) disable iff (rst)
    spill_we |-> spill_addr == sp + AW'(1)); // R5

  AST_FILL_SLOT_AT_SP: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_push) |-> $past(fill_addr) == sp); // R6

  AST_AHEAD_POINTER_SETTLES: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> sp_ahead == sp); // R8

endmodule

// File: tb/stack_exec_unit_test.sv
module stack_exec_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  localparam logic [2:0] C_LDI = 3'd0, C_DUP = 3'd1, C_DROP = 3'd2, C_ADD = 3'd3,
                         C_SUB = 3'd4, C_AND = 3'd5, C_OR = 3'd6, C_XOR = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic [31:0] in_imm = '0;
  logic [31:0] tos, nos;
  logic [7:0]  sp;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference state
  logic [31:0] r_mem [256];
  logic [31:0] m_tos = '0, m_nos = '0;
  logic [7:0]  m_sp = '0;
  // Expected states one and two issues back
  logic [31:0] p1_tos = '0, p1_nos = '0, p2_tos = '0, p2_nos = '0;
  logic [7:0]  p1_sp = '0, p2_sp = '0;
  string       p1_req = "R1", p2_req = "R1";

  logic [31:0] operands [8];

  stack_exec_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_imm(in_imm),
    .tos(tos), .nos(nos), .sp(sp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic check_state(string req, logic [31:0] et, logic [31:0] en, logic [7:0] es);
    checks++;
    if (tos !== et || nos !== en || sp !== es) begin
      failures++;
      $display("FAIL %s: actual tos=%h nos=%h sp=%0d expected tos=%h nos=%h sp=%0d",
               req, tos, nos, sp, et, en, es);
    end
  endtask

  task automatic model_apply(logic v, logic [2:0] op, logic [31:0] imm);
    logic [31:0] res;
    if (!v) return;
    if (op == C_LDI || op == C_DUP) begin
      res = (op == C_LDI) ? imm : m_tos;
      r_mem[m_sp + 8'd1] = m_nos;
      m_nos = m_tos;
      m_tos = res;
      m_sp  = m_sp + 8'd1;
    end else begin
      case (op)
        C_DROP:  res = m_nos;
        C_ADD:   res = m_nos + m_tos;
        C_SUB:   res = m_nos - m_tos;
        C_AND:   res = m_nos & m_tos;
        C_OR:    res = m_nos | m_tos;
        default: res = m_nos ^ m_tos;
      endcase
      m_tos = res;
      m_nos = r_mem[m_sp];
      m_sp  = m_sp - 8'd1;
    end
  endtask

  // One cycle: check the state due now (R2 timing), then issue.
  task automatic step(logic v, logic [2:0] op, logic [31:0] imm, string req);
    @(negedge clk);
    check_state(p2_req, p2_tos, p2_nos, p2_sp);
    p2_tos = p1_tos; p2_nos = p1_nos; p2_sp = p1_sp; p2_req = p1_req;
    model_apply(v, op, imm);
    p1_tos = m_tos; p1_nos = m_nos; p1_sp = m_sp; p1_req = req;
    in_valid = v; in_op = op; in_imm = imm;
  endtask

  task automatic drain(string req);
    step(1'b0, 3'd5, 32'hDEAD_BEEF, req);
    step(1'b0, 3'd2, 32'h0BAD_F00D, req);
  endtask

  initial begin
    operands[0] = 32'h0000_0000; operands[1] = 32'h0000_0001;
    operands[2] = 32'hFFFF_FFFF; operands[3] = 32'h7FFF_FFFF;
    operands[4] = 32'h8000_0000; operands[5] = 32'hA5A5_A5A5;
    operands[6] = 32'h1234_5678; operands[7] = 32'h0F0F_00FF;

    // R1: reset state, with junk on the inputs
    in_valid = 1'b1; in_op = C_LDI; in_imm = 32'h5555_AAAA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check_state("R1", 32'h0, 32'h0, 8'd0);

    // R3/R5/R11: push past the full depth so every slot is written
    for (int i = 0; i < 260; i++)
      step(1'b1, C_LDI, 32'h1000_0000 + i * 7919, (i < 250) ? "R5" : "R11");
    // R6/R11: pop back through every slot and wrap below zero
    for (int i = 0; i < 262; i++)
      step(1'b1, C_DROP, 32'hFFFF_0000 + i, (i < 250) ? "R6" : "R11");
    drain("R9");

    // R4: duplicate
    step(1'b1, C_LDI, 32'hCAFE_0001, "R3");
    for (int i = 0; i < 4; i++) step(1'b1, C_DUP, 32'h0, "R4");

    // R8: push then pop back to back
    for (int i = 0; i < 24; i++) begin
      step(1'b1, C_LDI, 32'h2000_0000 ^ (i * 32'h0101_0101), "R8");
      step(1'b1, C_DROP, 32'h0, "R8");
      step(1'b1, C_DUP, 32'h0, "R8");
      step(1'b1, C_ADD, 32'h0, "R8");
    end

    // R7: every operand pair against every two-operand op
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int op = 3; op < 8; op++) begin
          step(1'b1, C_LDI, operands[a], "R7");
          step(1'b1, C_LDI, operands[b], "R7");
          step(1'b1, 3'(op), 32'h0, "R7");
        end

    // R9: idle cycles with garbage on op and immediate
    for (int i = 0; i < 16; i++)
      step(1'b0, 3'(i), 32'h7777_0000 + i, "R9");

    // R10: negate via four instructions, compared with arithmetic negation
    for (int k = 0; k < 8; k++) begin
      step(1'b1, C_LDI, operands[k], "R10");
      step(1'b1, C_LDI, 32'hFFFF_FFFF, "R10");
      step(1'b1, C_XOR, 32'h0, "R10");
      step(1'b1, C_LDI, 32'h1, "R10");
      step(1'b1, C_ADD, 32'h0, "R10");
      drain("R10");
      checks++;
      if (tos !== (32'h0 - operands[k])) begin
        failures++;
        $display("FAIL R10: actual tos=%h expected %h", tos, 32'h0 - operands[k]);
      end
    end

    // R2: dense back-to-back stream mixing all ops
    for (int i = 0; i < 40; i++)
      step(1'b1, (i % 3 == 0) ? C_LDI : 3'((i % 6) + 2), 32'h3000_0000 + i * 13, "R2");
    drain("R2");

    finish_run();
  end

endmodule